// File: doc/BRIEF.md
# Concurrent Test-Pattern Response Monitor

This block sits next to a combinational circuit under test (or next to the combinational core of a sequential one, with its state flops treated as extra inputs and extra outputs). Every clock cycle it watches the live input vector and the response of that circuit. It never drives stimulus. Instead it holds a compile-time table of partially specified test patterns. Each entry has a care mask and a value on the inputs, and an observe mask and an expected value on the outputs. When normal traffic happens to hit an entry on its care bits, only the observed outputs of that entry are compared with the expected response.

The observed pair arrives as a stream beat qualified by `obs_valid`. The monitor is always ready and never applies back-pressure, so there is no ready signal. A beat with `obs_valid` low is not examined. Each accepted beat is first captured in a register stage, which keeps the compare logic off the critical path of the circuit under test. The compare result is registered one cycle later into a sticky error flag. A one-cycle pulse marks the first mismatch. A per-pattern hit vector records which entries have occurred, and `all_hit` reports that the concurrent test is complete. A synchronous `clr` restarts both the error and the coverage record.

Pattern tables are packed parameters. Entry p uses input bits [p*N_IN +: N_IN] and output bits [p*N_OUT +: N_OUT]. Input bit 0 of the observed vector is the first circuit input.

Top module: `ctm_monitor`

## Requirements
- R1: A captured input vector matches entry p when it equals the entry's input value on every bit whose care-mask bit is 1. Bits whose care-mask bit is 0 never affect the match.
- R2: For a matching entry, only output bits whose observe-mask bit is 1 are compared with the expected value. A difference on any other output bit never raises an error.
- R3: The error condition is the OR over all entries of (match AND observed mismatch). When several entries match the same vector, all of their checks apply, and a failure in any one of them raises the error.
- R4: A failing beat presented with `obs_valid`=1 before rising edge k sets `err_flag` after edge k+1, not earlier. `err_flag` then stays 1 until `clr` or reset.
- R5: `err_pulse` is 1 for exactly the one cycle in which `err_flag` goes from 0 to 1. It is 0 for any later failure while the flag is already set.
- R6: Bit p of `hit_vec` is set one cycle after a captured beat matches entry p, whatever the outputs are. The bit stays set. `all_hit` is 1 exactly when every bit of `hit_vec` is 1.
- R7: With `clr`=1 at a rising edge, `err_flag`, `err_pulse` and `hit_vec` become 0. A beat presented in that same cycle is discarded and is never checked or counted.
- R8: A beat with `obs_valid`=0 never changes `err_flag`, `err_pulse` or `hit_vec`.
- R9: After reset (`rst_n`=0, synchronous, active low) all outputs are 0.
- R10: Each entry may specify up to MAX_CARE input bits (default 32), and an entry at that limit is matched normally. A table with an entry above the limit is flagged by an elaboration-time check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of error and hit record |
| obs_valid | input | 1 | Observed beat is valid (monitor is always ready) |
| obs_in | input | N_IN | Live inputs of the circuit under test (pseudo inputs included) |
| obs_out | input | N_OUT | Live outputs of the circuit under test (pseudo outputs included) |
| err_flag | output | 1 | Sticky response-mismatch flag |
| err_pulse | output | 1 | One-cycle marker of the first mismatch |
| hit_vec | output | N_PAT | Per-entry occurrence record |
| all_hit | output | 1 | Every entry has occurred at least once |

## Verification
A bad capture register or a mis-sliced table entry shows up at the ports two edges after the offending beat. It appears either as `err_flag` rising on a good response or as a wrong bit in `hit_vec`. An error latch that loses its state shows up as `err_flag` dropping without a clear, and a latch that re-arms shows up as a second `err_pulse`; both are visible within one cycle of the next failing beat. A hit record that drops or skips bits leaves `all_hit` low after every entry has been hit. A clear that does not flush the capture stage lets a stale failure appear one cycle after `clr`.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

  // Care-bit limit per entry used when the integrator gives none
  localparam int DEF_MAX_CARE = 32;

  // Per-entry verdict for the captured beat
  typedef struct packed {
    logic hit;   // entry occurred on the captured inputs
    logic fail;  // entry occurred and an observed output differed
  } ctm_verdict_t;

endpackage

// File: rtl/ctm_sample_reg.sv
module ctm_sample_reg #(
  parameter int N_IN  = 5,
  parameter int N_OUT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             obs_valid,
  input  logic [N_IN-1:0]  obs_in,
  input  logic [N_OUT-1:0] obs_out,
  output logic             s_valid,
  output logic [N_IN-1:0]  s_in,
  output logic [N_OUT-1:0] s_out
);

  // Capture stage: isolates the compare cone from the circuit's own paths
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_in    <= '0;
      s_out   <= '0;
    end else begin
      s_valid <= obs_valid & ~clr;
      s_in    <= obs_in;
      s_out   <= obs_out;
    end
  end

  // R8
  invalid_not_captured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !obs_valid |=> !s_valid);

  // R7
  clr_flushes_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !s_valid);

endmodule

// File: rtl/ctm_pattern_check.sv
module ctm_pattern_check #(
  parameter int               N_IN     = 5,
  parameter int               N_OUT    = 2,
  parameter int               MAX_CARE = ctm_pkg::DEF_MAX_CARE,
  parameter logic [N_IN-1:0]  CARE     = '0,
  parameter logic [N_IN-1:0]  IVAL     = '0,
  parameter logic [N_OUT-1:0] OMASK    = '0,
  parameter logic [N_OUT-1:0] OVAL     = '0
) (
  input  logic                 s_valid,
  input  logic [N_IN-1:0]      s_in,
  input  logic [N_OUT-1:0]     s_out,
  output ctm_pkg::ctm_verdict_t verdict
);

  logic [N_IN-1:0]  in_diff;
  logic [N_OUT-1:0] out_diff;
  logic             occurs;
  logic             differs;

  // Ternary match: only cared bits may disagree with the stored value
  assign in_diff  = (s_in ^ IVAL) & CARE;
  assign occurs   = s_valid && (in_diff == '0);

  // Masked compare on the observed outputs of this entry
  assign out_diff = (s_out ^ OVAL) & OMASK;
  assign differs  = (out_diff != '0);

  assign verdict.hit  = occurs;
  assign verdict.fail = occurs && differs;

  // R10
  initial begin
    care_limit_chk: assert ($countones(CARE) <= MAX_CARE);
  end

endmodule

// File: rtl/ctm_hit_track.sv
module ctm_hit_track #(
  parameter int N_PAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [N_PAT-1:0] hit_now,
  output logic [N_PAT-1:0] hit_vec,
  output logic             all_hit
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) hit_vec <= '0;
    else               hit_vec <= hit_vec | hit_now;
  end

  assign all_hit = &hit_vec;

  // R6
  hits_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((hit_vec & $past(hit_vec)) == $past(hit_vec)));

  // R6
  hit_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && hit_now != '0) |=> ((hit_vec & $past(hit_now)) == $past(hit_now)));

endmodule

// File: rtl/ctm_err_latch.sv
module ctm_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic any_fail,
  output logic err_flag,
  output logic err_pulse
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      err_flag  <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= any_fail & ~err_flag;
      if (any_fail) err_flag <= 1'b1;
    end
  end

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr) |=> err_flag);

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  // R5
  pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_flag && !$past(err_flag)));

endmodule

// File: rtl/ctm_monitor.sv
module ctm_monitor #(
  parameter int                     N_IN      = 5,
  parameter int                     N_OUT     = 2,
  parameter int                     N_PAT     = 2,
  parameter int                     MAX_CARE  = ctm_pkg::DEF_MAX_CARE,
  parameter logic [N_PAT*N_IN-1:0]  CARE_TAB  = 10'b01011_01101,
  parameter logic [N_PAT*N_IN-1:0]  VAL_TAB   = 10'b00001_01101,
  parameter logic [N_PAT*N_OUT-1:0] OMASK_TAB = 4'b10_10,
  parameter logic [N_PAT*N_OUT-1:0] OVAL_TAB  = 4'b00_00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             obs_valid,
  input  logic [N_IN-1:0]  obs_in,
  input  logic [N_OUT-1:0] obs_out,
  output logic             err_flag,
  output logic             err_pulse,
  output logic [N_PAT-1:0] hit_vec,
  output logic             all_hit
);

  logic                  s_valid;
  logic [N_IN-1:0]       s_in;
  logic [N_OUT-1:0]      s_out;
  ctm_pkg::ctm_verdict_t verd [N_PAT];
  logic [N_PAT-1:0]      hit_now;
  logic [N_PAT-1:0]      fail_now;
  logic                  any_fail;

  ctm_sample_reg #(.N_IN(N_IN), .N_OUT(N_OUT)) u_sample (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .obs_valid(obs_valid), .obs_in(obs_in), .obs_out(obs_out),
    .s_valid(s_valid), .s_in(s_in), .s_out(s_out)
  );

  for (genvar p = 0; p < N_PAT; p++) begin : g_entry
    ctm_pattern_check #(
      .N_IN(N_IN), .N_OUT(N_OUT), .MAX_CARE(MAX_CARE),
      .CARE (CARE_TAB [p*N_IN  +: N_IN]),
      .IVAL (VAL_TAB  [p*N_IN  +: N_IN]),
      .OMASK(OMASK_TAB[p*N_OUT +: N_OUT]),
      .OVAL (OVAL_TAB [p*N_OUT +: N_OUT])
    ) u_chk (
      .s_valid(s_valid), .s_in(s_in), .s_out(s_out), .verdict(verd[p])
    );
    assign hit_now[p]  = verd[p].hit;
    assign fail_now[p] = verd[p].fail;
  end

  // Every matching entry contributes its own verdict
  assign any_fail = |fail_now;

  ctm_hit_track #(.N_PAT(N_PAT)) u_hits (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .hit_now(hit_now), .hit_vec(hit_vec), .all_hit(all_hit)
  );

  ctm_err_latch u_err (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .any_fail(any_fail), .err_flag(err_flag), .err_pulse(err_pulse)
  );

  // R7
  clr_clears_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!err_flag && !err_pulse && hit_vec == '0));

  // R3
  fail_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fail_now & ~hit_now) == '0));

endmodule

// File: tb/ctm_monitor_bench.sv
module ctm_monitor_bench;

  localparam int N_IN  = 5;
  localparam int N_OUT = 2;
  localparam int N_PAT = 3;
  localparam int N_TAB = 9;
  localparam int EW    = N_IN + N_OUT + 1 + N_PAT;

  // Entry 0: a=1,c=1,d=1 checks g=0; entry 1: a=1,b=0,d=0 checks g=0;
  // entry 2: c=1 checks f=1. Input bit0=a..bit4=e, output bit0=f, bit1=g.
  // R10: entries 0 and 1 sit exactly at the MAX_CARE=3 limit.

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clr = 1'b0;
  logic             obs_valid = 1'b0;
  logic [N_IN-1:0]  obs_in = '0;
  logic [N_OUT-1:0] obs_out = '0;
  logic             err_flag, err_pulse, all_hit;
  logic [N_PAT-1:0] hit_vec;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ctm_monitor #(
    .N_IN(N_IN), .N_OUT(N_OUT), .N_PAT(N_PAT), .MAX_CARE(3),
    .CARE_TAB (15'b00100_01011_01101),
    .VAL_TAB  (15'b00100_00001_01101),
    .OMASK_TAB(6'b01_10_10),
    .OVAL_TAB (6'b01_00_00)
  ) u_ctm_monitor (
    .clk(clk), .rst_n(rst_n), .clr(clr), .obs_valid(obs_valid),
    .obs_in(obs_in), .obs_out(obs_out), .err_flag(err_flag),
    .err_pulse(err_pulse), .hit_vec(hit_vec), .all_hit(all_hit)
  );

  // {inputs edcba, outputs gf, expected fail, expected hits [2:0]}
  localparam logic [EW-1:0] TAB [N_TAB] = '{
    {5'b01101, 2'b01, 1'b0, 3'b101},  // R1 R3 R10 both entries match, both pass
    {5'b01101, 2'b11, 1'b1, 3'b101},  // R3 entry 0 fails on g
    {5'b01101, 2'b00, 1'b1, 3'b101},  // R3 entry 2 fails on f, entry 0 passes
    {5'b11111, 2'b01, 1'b0, 3'b101},  // R1 don't-care bits b,e flipped
    {5'b00001, 2'b00, 1'b0, 3'b010},  // R1 R10 entry 1 only
    {5'b10101, 2'b10, 1'b1, 3'b110},  // R3 entries 1 and 2 both fail
    {5'b00000, 2'b11, 1'b0, 3'b000},  // R1 no entry matches
    {5'b01100, 2'b11, 1'b0, 3'b100},  // R2 g differs but entry 2 observes f only
    {5'b01001, 2'b10, 1'b0, 3'b000}   // R1 cared bits c,d disagree
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic v, input logic [N_IN-1:0] i,
                       input logic [N_OUT-1:0] o);
    @(negedge clk);
    clr = c; obs_valid = v; obs_in = i; obs_out = o;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 err_flag", 32'(err_flag), 0);
    check("R9 err_pulse", 32'(err_pulse), 0);
    check("R9 hit_vec", 32'(hit_vec), 0);
    check("R9 all_hit", 32'(all_hit), 0);

    // Table walk: clear, one beat, idle, sample two edges after the beat
    for (int k = 0; k < N_TAB; k++) begin
      drive(1'b1, 1'b0, '0, '0);
      drive(1'b0, 1'b1, TAB[k][EW-1 -: N_IN], TAB[k][N_PAT+1 +: N_OUT]);
      drive(1'b0, 1'b0, '0, '0);
      @(negedge clk);
      check($sformatf("R1/R2/R3 entry %0d err_flag", k), 32'(err_flag), 32'(TAB[k][N_PAT]));
      check($sformatf("R5 entry %0d err_pulse", k), 32'(err_pulse), 32'(TAB[k][N_PAT]));
      check($sformatf("R6 entry %0d hit_vec", k), 32'(hit_vec), 32'(TAB[k][N_PAT-1:0]));
    end

    // R8: failing beat with valid low is ignored
    drive(1'b1, 1'b0, '0, '0);
    drive(1'b0, 1'b0, 5'b01101, 2'b11);
    drive(1'b0, 1'b0, '0, '0);
    @(negedge clk);
    check("R8 err_flag", 32'(err_flag), 0);
    check("R8 hit_vec", 32'(hit_vec), 0);

    // R4 timing and stickiness, R5 single pulse
    drive(1'b0, 1'b1, 5'b01101, 2'b11);
    drive(1'b0, 1'b1, 5'b01101, 2'b11);
    check("R4 not yet after one edge", 32'(err_flag), 0);
    drive(1'b0, 1'b0, '0, '0);
    check("R4 set after two edges", 32'(err_flag), 1);
    check("R5 first pulse", 32'(err_pulse), 1);
    @(negedge clk);
    check("R5 no second pulse", 32'(err_pulse), 0);
    check("R4 still set", 32'(err_flag), 1);
    repeat (3) @(negedge clk);
    check("R4 sticky", 32'(err_flag), 1);

    // R7: beat presented together with clr is discarded
    drive(1'b1, 1'b1, 5'b01101, 2'b11);
    drive(1'b0, 1'b0, '0, '0);
    check("R7 cleared", 32'(err_flag), 0);
    @(negedge clk);
    check("R7 same-cycle beat dropped", 32'(err_flag), 0);
    check("R7 same-cycle beat not hit", 32'(hit_vec), 0);

    // R6: all_hit only after every entry has occurred
    drive(1'b0, 1'b1, 5'b01101, 2'b01);
    drive(1'b0, 1'b1, 5'b00001, 2'b00);
    drive(1'b0, 1'b0, '0, '0);
    check("R6 partial hit_vec", 32'(hit_vec), 32'h5);
    check("R6 all_hit low", 32'(all_hit), 0);
    @(negedge clk);
    check("R6 full hit_vec", 32'(hit_vec), 32'h7);
    check("R6 all_hit high", 32'(all_hit), 1);
    check("R2 good responses keep err low", 32'(err_flag), 0);

    // R7: clr also empties the hit record
    drive(1'b1, 1'b0, '0, '0);
    drive(1'b0, 1'b0, '0, '0);
    check("R7 hit_vec cleared", 32'(hit_vec), 0);
    check("R7 all_hit cleared", 32'(all_hit), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule